// File: doc/BRIEF.md
# Device Address Register with Deferred Commit

This block keeps the active device address of a USB device-side serial interface engine. It also keeps two firmware-visible status flags. Firmware writes a new address through a small register port. A commit-mode flag decides when that address takes effect:

- With the flag clear, the address takes effect at the next clock edge.
- With the flag set, the written value waits in the address register. It is copied into the active address only when the host has successfully read IN data, which is signalled by a one-cycle acknowledge pulse. The block then clears the commit-mode flag by itself.

This lets firmware answer a set-address request and still finish the status stage under the old address.

The status register also holds a sticky flag for endpoint 0 FIFO access errors. Hardware sets the flag and firmware clears it. A USB bus reset returns the active address to 0 and disarms the deferred commit.

Top module: `usb_addr_ctrl`

## Requirements
- R1: After `rst_n` is released, the active address, the address register, the remote-wakeup bit, the commit-mode flag and the error flag are all 0.
- R2: When the commit-mode flag is 0, a write to the address register (`reg_sel`=0) makes `dev_addr` equal `reg_wdata[6:0]` from the next clock edge.
- R3: When the commit-mode flag is 1, writes to the address register leave `dev_addr` unchanged. The register reads back the latest written value, and each write replaces the pending value.
- R4: When the commit-mode flag is 1 and `in_ack` pulses, `dev_addr` takes the address register's bits [6:0] at that edge, and the commit-mode flag clears.
- R5: When the commit-mode flag is 0, an `in_ack` pulse has no effect on `dev_addr` or on either register.
- R6: `bus_rst` sets `dev_addr` to 0 and the commit-mode flag to 0 at the next edge, and overrides a same-cycle register write or `in_ack`. The address register and the error flag keep their values.
- R7: The status register (`reg_sel`=1) holds the commit-mode flag in bit 0 and the error flag in bit 1. An `ep0_err` pulse sets bit 1. Bit 1 stays set until a status write carries 1 in bit 1; a status write with 0 in bit 1 leaves it unchanged.
- R8: When `ep0_err` and a clearing status write arrive in the same cycle, the error flag stays set.
- R9: Status bits 7 down to 2 always read as 0, whatever was written.
- R10: Bit 7 of the address register is a remote-wakeup enable. It is stored and read back, and it never reaches `dev_addr`.
- R11: A status write that arrives together with an `in_ack` that commits an address sets the commit-mode flag to the written bit 0, overriding the automatic clear.
- R12: When `in_ack` commits in the same cycle as an address-register write, `dev_addr` takes the register value from before that write. The new value stays in the register and is not committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | USB bus reset seen on the line |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 address, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| in_ack | input | 1 | Pulse: host acknowledged IN data |
| ep0_err | input | 1 | Pulse: endpoint 0 FIFO access error |
| dev_addr | output | 7 | Active device address |

## Verification
Every stored result appears one clock edge after the stimulus that causes it:

- `dev_addr`, both registers and both flags change at the rising edge that samples the write, `in_ack`, `ep0_err` or `bus_rst`.
- `reg_rdata` is combinational from `reg_sel` and the stored state.

The bench drives each stimulus for exactly one cycle from the falling edge. It updates its reference model at the rising edge. At the following falling edge it compares `dev_addr` and reads both registers back through `reg_rdata`. So every effect, including a write that must have no effect, is checked exactly one edge after the stimulus and before the next one is applied.

// File: rtl/usb_addr_pkg.sv
package usb_addr_pkg;
  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  localparam int STAT_MODE_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;
endpackage

// File: rtl/uac_err_flag.sv
module uac_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // Hardware set dominates a firmware clear in the same cycle.
  function automatic logic f_next_flag(input logic cur, input logic set, input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= f_next_flag(flag_o, set_i, clr_i);
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/uac_active_addr.sv
module uac_active_addr #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_i,
  input  logic              wr_addr_i,
  input  logic              wr_stat_i,
  input  logic              stat_mode_i,
  input  logic              in_ack_i,
  input  logic [ADDR_W-1:0] wval_i,
  input  logic [ADDR_W-1:0] stored_i,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic              defer_o
);
  // Named events for the assertions.
  logic commit_deferred;
  logic commit_now;

  assign commit_deferred = defer_o && in_ack_i;
  assign commit_now      = !defer_o && wr_addr_i;

  function automatic logic [ADDR_W-1:0] f_next_addr(
    input logic              rst,
    input logic              ld_def,
    input logic              ld_now,
    input logic [ADDR_W-1:0] stored,
    input logic [ADDR_W-1:0] wval,
    input logic [ADDR_W-1:0] cur);
    if (rst)         return '0;
    else if (ld_def) return stored;
    else if (ld_now) return wval;
    else             return cur;
  endfunction

  function automatic logic f_next_mode(
    input logic rst, input logic fw_wr, input logic fw_val,
    input logic hw_clr, input logic cur);
    if (rst)         return 1'b0;
    else if (fw_wr)  return fw_val;
    else if (hw_clr) return 1'b0;
    else             return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_addr_o <= '0;
      defer_o    <= 1'b0;
    end else begin
      dev_addr_o <= f_next_addr(bus_rst_i, commit_deferred, commit_now,
                                stored_i, wval_i, dev_addr_o);
      defer_o    <= f_next_mode(bus_rst_i, wr_stat_i, stat_mode_i,
                                commit_deferred, defer_o);
    end
  end

  p_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!defer_o && wr_addr_i && !bus_rst_i) |=> dev_addr_o == $past(wval_i));
  p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_o && !in_ack_i && !bus_rst_i) |=> $stable(dev_addr_o));
  p_deferred_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_o && in_ack_i && !bus_rst_i) |=> dev_addr_o == $past(stored_i));
  p_auto_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_o && in_ack_i && !wr_stat_i) |=> !defer_o);
  p_idle_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!defer_o && !wr_addr_i && !bus_rst_i) |=> $stable(dev_addr_o));
  p_bus_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> (dev_addr_o == '0) && !defer_o);
  p_fw_mode_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat_i && !bus_rst_i) |=> defer_o == $past(stat_mode_i));
endmodule

// File: rtl/uac_regfile.sv
module uac_regfile
  import usb_addr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  reg_sel_e          sel_i,
  input  logic              mode_i,
  input  logic              err_i,
  output logic [ADDR_W-1:0] stored_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WAKE_BIT = ADDR_W;
  localparam int PAD_W    = DATA_W - 2;

  logic wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_o <= '0;
      wake_q   <= 1'b0;
    end else if (wr_addr_i) begin
      stored_o <= wdata_i[ADDR_W-1:0];
      wake_q   <= wdata_i[WAKE_BIT];
    end
  end

  logic [DATA_W-1:0] addr_view;
  logic [DATA_W-1:0] stat_view;

  assign addr_view = {wake_q, stored_o};
  assign stat_view = {{PAD_W{1'b0}}, err_i, mode_i};
  assign rdata_o   = (sel_i == SEL_STAT) ? stat_view : addr_view;

  p_stat_msb_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SEL_STAT) |-> rdata_o[DATA_W-1:2] == '0);
  p_replace_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr_i |=> stored_o == $past(wdata_i[ADDR_W-1:0]));
endmodule

// File: rtl/usb_addr_ctrl.sv
module usb_addr_ctrl
  import usb_addr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              in_ack,
  input  logic              ep0_err,
  output logic [ADDR_W-1:0] dev_addr
);
  reg_sel_e          sel;
  logic              wr_addr;
  logic              wr_stat;
  logic              err_clr;
  logic              defer_mode;
  logic              err_flag;
  logic [ADDR_W-1:0] stored_addr;

  assign sel     = reg_sel_e'(reg_sel);
  assign wr_addr = reg_wr && (sel == SEL_ADDR);
  assign wr_stat = reg_wr && (sel == SEL_STAT);
  assign err_clr = wr_stat && reg_wdata[STAT_ERR_BIT];

  uac_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_addr_i(wr_addr),
    .wdata_i  (reg_wdata),
    .sel_i    (sel),
    .mode_i   (defer_mode),
    .err_i    (err_flag),
    .stored_o (stored_addr),
    .rdata_o  (reg_rdata)
  );

  uac_active_addr #(.ADDR_W(ADDR_W)) u_active (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst_i  (bus_rst),
    .wr_addr_i  (wr_addr),
    .wr_stat_i  (wr_stat),
    .stat_mode_i(reg_wdata[STAT_MODE_BIT]),
    .in_ack_i   (in_ack),
    .wval_i     (reg_wdata[ADDR_W-1:0]),
    .stored_i   (stored_addr),
    .dev_addr_o (dev_addr),
    .defer_o    (defer_mode)
  );

  uac_err_flag u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ep0_err),
    .clr_i (err_clr),
    .flag_o(err_flag)
  );

  p_wake_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr && defer_mode && !in_ack && !bus_rst) |=> $stable(dev_addr));
  p_bus_rst_keeps_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && !reg_wr) |=> $stable(stored_addr));
  p_commit_old_value_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_mode && in_ack && wr_addr && !bus_rst) |=> dev_addr == $past(stored_addr));
endmodule

// File: tb/test_usb_addr_ctrl.sv
module test_usb_addr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       in_ack = 1'b0;
  logic       ep0_err = 1'b0;
  logic [6:0] dev_addr;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  int m_stor = 0, m_wake = 0, m_mode = 0, m_err = 0, m_dev = 0;

  always #2.5 clk = ~clk;

  usb_addr_ctrl i_usb_addr_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_ack(in_ack), .ep0_err(ep0_err), .dev_addr(dev_addr)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "dev_addr", int'(dev_addr), m_dev);
    reg_sel = 1'b0; #0.5;
    check(tag, "addr reg", int'(reg_rdata), m_wake * 128 + m_stor);
    reg_sel = 1'b1; #0.5;
    check(tag, "stat reg", int'(reg_rdata), m_err * 2 + m_mode);
    reg_sel = 1'b0;
  endtask

  task automatic step(input bit wr, input bit sel, input logic [7:0] d,
                      input bit ia, input bit er, input bit br, input string tag);
    int p_stor, p_mode;
    reg_wr = wr; reg_sel = sel; reg_wdata = d;
    in_ack = ia; ep0_err = er; bus_rst = br;
    @(posedge clk);
    p_stor = m_stor; p_mode = m_mode;
    if (wr && !sel) begin m_stor = int'(d[6:0]); m_wake = int'(d[7]); end
    if (br)                       m_dev = 0;
    else if (p_mode == 1 && ia)   m_dev = p_stor;
    else if (p_mode == 0 && wr && !sel) m_dev = int'(d[6:0]);
    if (br)                       m_mode = 0;
    else if (wr && sel)           m_mode = int'(d[0]);
    else if (p_mode == 1 && ia)   m_mode = 0;
    if (er)                       m_err = 1;
    else if (wr && sel && d[1])   m_err = 0;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00; in_ack = 1'b0; ep0_err = 1'b0; bus_rst = 1'b0;
    compare_all(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");
    step(0, 0, 8'h00, 0, 0, 0, "R1");
    // immediate mode
    step(1, 0, 8'h15, 0, 0, 0, "R2");
    step(1, 0, 8'h7F, 0, 0, 0, "R2");
    step(1, 0, 8'h85, 0, 0, 0, "R10");
    step(0, 0, 8'h00, 1, 0, 0, "R5");
    // deferred mode
    step(1, 1, 8'h01, 0, 0, 0, "R3");
    step(1, 0, 8'h22, 0, 0, 0, "R3");
    step(0, 0, 8'h00, 0, 0, 0, "R3");
    step(1, 0, 8'hB3, 0, 0, 0, "R3");
    step(0, 0, 8'h00, 1, 0, 0, "R4");
    step(0, 0, 8'h00, 1, 0, 0, "R5");
    // commit with a same-cycle address write
    step(1, 1, 8'h01, 0, 0, 0, "R12");
    step(1, 0, 8'h50, 0, 0, 0, "R12");
    step(1, 0, 8'h44, 1, 0, 0, "R12");
    // firmware re-arm wins over automatic clear
    step(1, 1, 8'h01, 0, 0, 0, "R11");
    step(1, 1, 8'h01, 1, 0, 0, "R11");
    step(1, 0, 8'h0A, 0, 0, 0, "R11");
    step(0, 0, 8'h00, 1, 0, 0, "R11");
    // bus reset
    step(1, 0, 8'h66, 0, 0, 1, "R6");
    step(1, 0, 8'h12, 0, 0, 0, "R6");
    step(1, 1, 8'h01, 0, 0, 0, "R6");
    step(0, 0, 8'h00, 1, 1, 1, "R6");
    // error flag
    step(0, 0, 8'h00, 0, 1, 0, "R7");
    step(0, 0, 8'h00, 0, 0, 0, "R7");
    step(1, 1, 8'h00, 0, 0, 0, "R7");
    step(1, 1, 8'h02, 0, 0, 0, "R7");
    step(0, 0, 8'h00, 0, 1, 0, "R8");
    step(1, 1, 8'h02, 0, 1, 0, "R8");
    step(1, 1, 8'h02, 0, 0, 0, "R8");
    // unused status bits
    step(1, 1, 8'hFF, 0, 0, 0, "R9");
    step(1, 1, 8'hFC, 0, 1, 0, "R9");
    // mixed traffic against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], lfsr[15:8], lfsr[2] & lfsr[3], lfsr[4] & lfsr[5],
           lfsr[6] & lfsr[7] & lfsr[3], "R2_R4_R7");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule